// File: doc/BRIEF.md
# Eight-Pin I/O Port with Peripheral Takeover

This block controls an eight-pin general-purpose I/O port. Software programs it through a simple single-cycle register port. Three read/write registers hold the output latch, the per-pin direction and the per-pin reduced-drive select. A fourth register is read-only and returns the synchronized pad inputs.

For each pin, the block works out the final output enable, output value and drive-strength select that go to the pad. Two outside sources can take a pin over:

- A PWM block, with one enable and one data bit per channel.
- An SPI block, which supplies its own direction and data for the pins named in a parameter mask.

Software regains control of a pin in the same cycle that the peripheral lets go of it. PWM channel 7 has a shutdown mode that turns its pin into an input instead of an output.

Pad inputs pass through a two-stage synchronizer before software can read them. The core reset is asserted asynchronously and released synchronously inside the block.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, the latch, direction and drive registers read 0. Every `pad_oe` and `pad_rdrv` bit is 0.
- R2: The register addresses are: 0 for the data latch, 1 for direction, 2 for reduced drive and 3 for the input register. Registers 0 to 2 can be written and read at any time, and a write is visible on the next read. A write to address 3 is ignored.
- R3: A pin that no peripheral claims takes its `pad_oe` from its direction bit (1 = output) and its `pad_do` from its latch bit.
- R4: A pin whose `pwm_en` bit is 1 and that the SPI does not claim is an output, driving its `pwm_out` bit.
- R5: When pin 7 is claimed by PWM and `pwm_shutdown` is 1, the pin is an input (`pad_oe` = 0) and `pad_do` falls back to latch bit 7.
- R6: While `spi_en` is 1, every pin in `SPI_MASK` (default 8'h3C, pins 2 to 5) takes `pad_oe` and `pad_do` from `spi_oe` and `spi_do`. This holds whatever the direction bit or PWM says. Pins outside the mask ignore the SPI.
- R7: When a peripheral drops its enable, the pin returns to direction and latch control in the same cycle.
- R8: `pad_rdrv` equals the pin's reduced-drive bit (1 = reduced) when the pin is an output, and 0 when it is an input.
- R9: A read of address 0 returns the latch bit for pins that are currently outputs and the synchronized pad bit for pins that are inputs. A read of address 3 always returns the synchronized pad value.
- R10: A change on `pad_in` appears in the synchronized value two clock edges later, not one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle |
| pwm_en | input | 8 | Per-channel PWM enable |
| pwm_out | input | 8 | Per-channel PWM output value |
| pwm_shutdown | input | 1 | Shutdown mode on channel 7 |
| spi_en | input | 1 | SPI enable |
| spi_oe | input | 8 | SPI-requested direction per pin |
| spi_do | input | 8 | SPI output value per pin |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Resolved output enable |
| pad_do | output | 8 | Resolved output value |
| pad_rdrv | output | 8 | Reduced-drive select |

## Verification
The checker tests the direction arbitration on every cycle:

- SPI ownership of the masked pins.
- Forced output on PWM-owned pins.
- The channel 7 shutdown forcing an input.
- Direction-register control of unclaimed pins.
- No reduced-drive select on an input.
- The synchronizer's two-cycle delay.

Only the bench scenarios can show the following:

- Register readback and the ignored write to the input register.
- The mixed latch and pad content of a data read.
- Pad output values under each combination of overrides.
- The same-cycle return to software control.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_LATCH = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIR   = 2'd1;
  localparam logic [ADDR_W-1:0] A_RDRV  = 2'd2;
  localparam logic [ADDR_W-1:0] A_INPUT = 2'd3;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [gpio_ovr_pkg::ADDR_W-1:0]       addr,
  input  logic [W-1:0]                          wdata,
  output logic [W-1:0]                          latch_q,
  output logic [W-1:0]                          dir_q,
  output logic [W-1:0]                          rdrv_q
);
  import gpio_ovr_pkg::*;

  logic          latch_ce, dir_ce, rdrv_ce;
  logic [W-1:0]  latch_d, dir_d, rdrv_d;

  always_comb begin
    latch_ce = wr_en && (addr == A_LATCH);
    dir_ce   = wr_en && (addr == A_DIR);
    rdrv_ce  = wr_en && (addr == A_RDRV);
    latch_d  = latch_ce ? wdata : latch_q;
    dir_d    = dir_ce   ? wdata : dir_q;
    rdrv_d   = rdrv_ce  ? wdata : rdrv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      rdrv_q  <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
      rdrv_q  <= rdrv_d;
    end
  end
endmodule

// File: rtl/gpio_pin_arb.sv
module gpio_pin_arb #(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] SPI_MASK = 8'h3C,
  parameter int unsigned SD_PIN   = 7
) (
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] rdrv_q,
  input  logic [W-1:0] pwm_en,
  input  logic [W-1:0] pwm_out,
  input  logic         pwm_shutdown,
  input  logic         spi_en,
  input  logic [W-1:0] spi_oe,
  input  logic [W-1:0] spi_do,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_do,
  output logic [W-1:0] pad_rdrv
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic spi_claim;
    logic sd_here;
    assign spi_claim = spi_en && SPI_MASK[i];
    if (i == SD_PIN) begin : g_sd
      assign sd_here = pwm_shutdown;
    end else begin : g_nosd
      assign sd_here = 1'b0;
    end

    always_comb begin
      if (spi_claim) begin
        pad_oe[i] = spi_oe[i];
        pad_do[i] = spi_do[i];
      end else if (pwm_en[i] && sd_here) begin
        pad_oe[i] = 1'b0;
        pad_do[i] = latch_q[i];
      end else if (pwm_en[i]) begin
        pad_oe[i] = 1'b1;
        pad_do[i] = pwm_out[i];
      end else begin
        pad_oe[i] = dir_q[i];
        pad_do[i] = latch_q[i];
      end
      pad_rdrv[i] = pad_oe[i] && rdrv_q[i];
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = din;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
  parameter int unsigned  W        = 8,
  parameter logic [W-1:0] SPI_MASK = 8'h3C,
  parameter int unsigned  SD_PIN   = 7,
  parameter int unsigned  SYNC_N   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pwm_en,
  input  logic [W-1:0] pwm_out,
  input  logic         pwm_shutdown,
  input  logic         spi_en,
  input  logic [W-1:0] spi_oe,
  input  logic [W-1:0] spi_do,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_do,
  output logic [W-1:0] pad_rdrv
);
  import gpio_ovr_pkg::*;

  logic [1:0]   rst_pipe_q;
  logic         rst_core_n;
  logic [W-1:0] latch_q, dir_q, rdrv_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(bus_sel && bus_wr),
    .addr(bus_addr), .wdata(bus_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .rdrv_q(rdrv_q)
  );

  gpio_pin_arb #(.W(W), .SPI_MASK(SPI_MASK), .SD_PIN(SD_PIN)) u_arb (
    .latch_q(latch_q), .dir_q(dir_q), .rdrv_q(rdrv_q),
    .pwm_en(pwm_en), .pwm_out(pwm_out), .pwm_shutdown(pwm_shutdown),
    .spi_en(spi_en), .spi_oe(spi_oe), .spi_do(spi_do),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_rdrv(pad_rdrv)
  );

  gpio_in_sync #(.W(W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .din(pad_in), .dout(sync_q)
  );

  always_comb begin
    unique case (bus_addr)
      A_LATCH: bus_rdata = (latch_q & pad_oe) | (sync_q & ~pad_oe);
      A_DIR:   bus_rdata = dir_q;
      A_RDRV:  bus_rdata = rdrv_q;
      default: bus_rdata = sync_q;
    endcase
  end
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
  parameter int unsigned  W        = 8,
  parameter logic [W-1:0] SPI_MASK = 8'h3C,
  parameter int unsigned  SD_PIN   = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] pwm_en,
  input logic         pwm_shutdown,
  input logic         spi_en,
  input logic [W-1:0] spi_oe,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] sync_q,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_rdrv
);
  localparam logic [W-1:0] SD_BIT = W'(1) << SD_PIN;

  logic [W-1:0] spi_set, sd_set, free_set;
  logic [1:0]   age_q;

  assign spi_set  = spi_en ? SPI_MASK : '0;
  assign sd_set   = pwm_shutdown ? SD_BIT : '0;
  assign free_set = ~spi_set & ~pwm_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  p_spi_owns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ spi_oe) & spi_set) == '0);
  p_pwm_output_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en & ~spi_set & ~sd_set & ~pad_oe) == '0);
  p_shutdown_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en[SD_PIN] && pwm_shutdown && !spi_set[SD_PIN]) |-> !pad_oe[SD_PIN]);
  p_sw_direction_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ dir_q) & free_set) == '0);
  p_no_rdrv_on_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_rdrv & ~pad_oe) == '0);
  p_sync_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync_q == $past(pad_in, 2)));
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.W(W), .SPI_MASK(SPI_MASK), .SD_PIN(SD_PIN)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .pwm_en(pwm_en), .pwm_shutdown(pwm_shutdown),
  .spi_en(spi_en), .spi_oe(spi_oe), .dir_q(dir_q), .pad_in(pad_in),
  .sync_q(sync_q), .pad_oe(pad_oe), .pad_rdrv(pad_rdrv)
);

// File: tb/gpio_ovr_port_bench.sv
`timescale 1ns/1ps
module gpio_ovr_port_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] pwm_en, pwm_out, spi_oe, spi_do, pad_in, pad_oe, pad_do, pad_rdrv;
  logic       pwm_shutdown, spi_en;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_ovr_port u_gpio_ovr_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_en(pwm_en), .pwm_out(pwm_out), .pwm_shutdown(pwm_shutdown),
    .spi_en(spi_en), .spi_oe(spi_oe), .spi_do(spi_do), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_rdrv(pad_rdrv)
  );

  // {spi_en, pwm_en, pwm_out, shutdown, spi_oe, spi_do, exp_oe, exp_do, exp_rdrv}
  // fixed: dir=F0, latch=A5, rdrv=5A
  localparam logic [71:0] VEC [0:7] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'hA5, 8'h50},  // R3
    {8'h00, 8'h0F, 8'h0A, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hAA, 8'h5A},  // R4
    {8'h00, 8'h80, 8'h00, 8'h01, 8'h00, 8'h00, 8'h70, 8'hA5, 8'h50},  // R5
    {8'h00, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h25, 8'h50},  // R4
    {8'h01, 8'h00, 8'h00, 8'h00, 8'hCF, 8'h84, 8'hCC, 8'h85, 8'h48},  // R6
    {8'h01, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hC3, 8'hC3, 8'h42},  // R6
    {8'h00, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h00, 8'h7F, 8'h80, 8'h5A},  // R5
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'hA5, 8'h50}   // R7
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 20000) begin @(posedge clk); wd++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    pwm_en = 0; pwm_out = 0; pwm_shutdown = 0; spi_en = 0; spi_oe = 0; spi_do = 0;
    pad_in = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd1, r); chk("R1 dir", r, 8'h00);
    rd(2'd2, r); chk("R1 rdrv reg", r, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_rdrv", pad_rdrv, 8'h00);

    // R2 register access
    wr(2'd0, 8'hA5); wr(2'd1, 8'hF0); wr(2'd2, 8'h5A);
    rd(2'd1, r); chk("R2 dir readback", r, 8'hF0);
    rd(2'd2, r); chk("R2 rdrv readback", r, 8'h5A);
    wr(2'd3, 8'hFF);
    rd(2'd3, r); chk("R2 input write ignored", r, 8'h3C);
    rd(2'd1, r); chk("R2 dir untouched", r, 8'hF0);

    // R9 data read mixes latch and pad
    rd(2'd0, r); chk("R9 data read", r, 8'hAC);

    // table: R3..R8
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      {spi_en, pwm_en, pwm_out, pwm_shutdown, spi_oe, spi_do} =
        {VEC[k][71:64] != 0, VEC[k][63:56], VEC[k][55:48], VEC[k][47:40] != 0,
         VEC[k][39:32], VEC[k][31:24]};
      #0.5;
      chk($sformatf("R3-7 vec%0d oe", k), pad_oe, VEC[k][23:16]);
      chk($sformatf("R3-7 vec%0d do", k), pad_do, VEC[k][15:8]);
      chk($sformatf("R8 vec%0d rdrv", k), pad_rdrv, VEC[k][7:0]);
    end

    // R7 PWM release returns pin 0 within the same cycle
    @(negedge clk); pwm_en = 8'h01; pwm_out = 8'h00;
    #0.5 chk("R7 pwm owns", pad_oe, 8'hF1);
    pwm_en = 8'h00;
    #0.5 chk("R7 released", pad_oe, 8'hF0);
    chk("R7 released do", pad_do, 8'hA5);

    // R10 two-edge latency on input register
    @(negedge clk); pad_in = 8'hC3;
    @(negedge clk); rd(2'd3, r); chk("R10 after one edge", r, 8'h3C);
    @(negedge clk); rd(2'd3, r); chk("R10 after two edges", r, 8'hC3);

    // R9 direction change: all inputs -> data read shows pad
    wr(2'd1, 8'h00);
    rd(2'd0, r); chk("R9 all inputs", r, 8'hC3);
    chk("R8 inputs no rdrv", pad_rdrv, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd0, r); chk("R9 all outputs", r, 8'hA5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule